// File: doc/BRIEF.md
# Dual-Channel IDE I/O Address Decoder

This block sits beside a two-channel IDE controller and decides, for every I/O cycle address presented to it, whether the cycle belongs to the command block or the control block of the primary or secondary channel. Each channel works on its own in one of two modes. In the fixed compatibility mode it answers at the traditional addresses. In the relocatable mode it answers at addresses taken from a pair of base address registers.

Software programs the block through a small byte-wide configuration bus. The configuration covers a programming-interface byte that holds the per-channel mode bits, four base address registers split into low and high bytes, a command byte with an I/O-space enable, and one enable byte per channel. The block also turns a 3-bit interrupt select code into an interrupt line number, and reports for each channel whether its interrupt behaves as a shared PCI interrupt or as a legacy edge interrupt.

The block has no data stream and no valid/ready handshake. Configuration writes are single-cycle strobes and are always accepted. Reads are combinational. The decode outputs are plain level signals, so back-pressure does not apply.

Top module: `ide_decode_top`

## Requirements
- R1: After reset the programming-interface byte (offset 0x09) reads 0x8A, every base address register low byte (0x10, 0x14, 0x18, 0x1C) reads 0x01, high bytes (0x11, 0x15, 0x19, 0x1D) read 0x00, the command byte (0x04) reads 0x00, and no hit output is active.
- R2: Only bits 0 and 2 of the programming-interface byte are writable. All other bits keep their reset value (0x8A pattern).
- R3: A write to a command-block base register low byte (0x10, 0x18) stores the data ANDed with 0xF8 and ORed with 0x01. A write to a control-block base register low byte (0x14, 0x1C) stores the data ANDed with 0xFC and ORed with 0x01. High bytes store the full data.
- R4: A channel whose mode bit is 0 decodes its command block at 0x1F0 (primary) or 0x170 (secondary), and its control address at 0x3F6 (primary) or 0x376 (secondary).
- R5: A channel whose mode bit is 1 uses the command base {high byte, low byte AND 0xF8} and the control address {high byte, low byte AND 0xFC} + 2. The primary channel takes these from the registers at 0x10/0x11 and 0x14/0x15. The secondary channel takes them from 0x18/0x19 and 0x1C/0x1D.
- R6: A command-block hit covers the 8 consecutive addresses starting at the command base. A control-block hit covers only the single control address.
- R7: A channel produces hits only while command bit 0 is 1 and bit 7 of its enable byte (0x41 primary, 0x43 secondary) is 1. The command byte keeps only bits 0 and 2 of a write. An enable byte keeps the data ANDed with 0xF3.
- R8: Programming-interface bit 0 selects the mode of the primary channel and bit 2 selects the mode of the secondary channel, independently of each other. On cmd_hit, ctl_hit and irq_native, bit 0 is the primary channel and bit 1 is the secondary channel.
- R9: Bits 2:0 of the byte at 0x44 form the interrupt select code. Codes 0 to 7 give irq_line values 3, 5, 7, 8, 11, 12, 14 and 15. The upper five bits of that byte read 0.
- R10: irq_native for a channel is 1 (shared PCI interrupt) when that channel is in relocatable mode, and 0 (legacy edge interrupt) otherwise.
- R11: Hit outputs follow io_addr combinationally. A configuration write changes the decode only from the clock edge on which it is captured. Before that edge the old configuration still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset for reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data at cfg_addr, combinational |
| io_addr | input | 16 | I/O cycle address being decoded |
| cmd_hit | output | 2 | Command-block hit, bit 0 primary, bit 1 secondary |
| ctl_hit | output | 2 | Control-block hit, bit 0 primary, bit 1 secondary |
| irq_line | output | 4 | Interrupt line number selected by the 3-bit code |
| irq_native | output | 2 | Per-channel interrupt mode, 1 shared PCI, 0 legacy edge |

## Verification
The decode is driven with addresses in four mode settings: both channels fixed, both relocatable, and each of the two mixed settings. In every setting the bench tries the first and last address of each command window, the addresses just outside it, and each control address together with its neighbours. This separates a wrong base from a wrong window size or a wrong control offset. The mixed settings show whether one channel's mode bit leaks into the other. The old fixed addresses, probed while a channel is relocatable, show that the mode switch really moves the window. Separate tests clear the I/O enable bit and one channel's enable byte, and observe the hits on both sides of the capturing edge.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int CH_N      = 2;
  localparam int BAR_N     = 2 * CH_N;
  localparam int IO_AW     = 16;
  localparam int CMD_SPAN_LOG2 = 3;

  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_PIF  = 8'h09;
  localparam logic [7:0] OFF_BAR0 = 8'h10;
  localparam logic [7:0] OFF_EN0  = 8'h41;
  localparam logic [7:0] OFF_IRQ  = 8'h44;

  localparam logic [7:0] PIF_RST    = 8'h8A;
  localparam logic [7:0] PIF_WMASK  = 8'h05;
  localparam logic [7:0] CMD_WMASK  = 8'h05;
  localparam logic [7:0] EN_WMASK   = 8'hF3;
  localparam logic [7:0] BAR_LO_RST = 8'h01;
  localparam logic [7:0] CMD_LO_MASK = 8'hF8;
  localparam logic [7:0] CTL_LO_MASK = 8'hFC;

  localparam logic [CH_N-1:0][IO_AW-1:0] LEG_CMD = {16'h0170, 16'h01F0};
  localparam logic [CH_N-1:0][IO_AW-1:0] LEG_CTL = {16'h0376, 16'h03F6};

  function automatic logic [3:0] irq_code_to_line(input logic [2:0] code);
    logic [3:0] line;
    case (code)
      3'd0: line = 4'd3;
      3'd1: line = 4'd5;
      3'd2: line = 4'd7;
      3'd3: line = 4'd8;
      3'd4: line = 4'd11;
      3'd5: line = 4'd12;
      3'd6: line = 4'd14;
      default: line = 4'd15;
    endcase
    return line;
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  output logic [7:0]                 cfg_rdata,
  output logic                       io_en,
  output logic [CH_N-1:0]            native,
  output logic [CH_N-1:0]            chan_en,
  output logic [BAR_N-1:0][7:0]      bar_lo,
  output logic [BAR_N-1:0][7:0]      bar_hi,
  output logic [2:0]                 irq_code
);
  logic [7:0]           cmd_q;
  logic [7:0]           pif_q;
  logic [2:0]           irq_q;
  logic [CH_N-1:0][7:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 8'h00;
      pif_q <= PIF_RST;
      irq_q <= 3'd0;
    end else if (cfg_wr) begin
      if (cfg_addr == OFF_CMD) cmd_q <= cfg_wdata & CMD_WMASK;
      if (cfg_addr == OFF_PIF) pif_q <= (pif_q & ~PIF_WMASK) | (cfg_wdata & PIF_WMASK);
      if (cfg_addr == OFF_IRQ) irq_q <= cfg_wdata[2:0];
    end
  end

  for (genvar i = 0; i < BAR_N; i++) begin : g_bar
    localparam logic [7:0] LO_OFF  = OFF_BAR0 + 8'(4 * i);
    localparam logic [7:0] HI_OFF  = LO_OFF + 8'd1;
    localparam logic [7:0] LO_MASK = (i % 2 == 0) ? CMD_LO_MASK : CTL_LO_MASK;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bar_lo[i] <= BAR_LO_RST;
        bar_hi[i] <= 8'h00;
      end else if (cfg_wr) begin
        if (cfg_addr == LO_OFF) bar_lo[i] <= (cfg_wdata & LO_MASK) | 8'h01;
        if (cfg_addr == HI_OFF) bar_hi[i] <= cfg_wdata;
      end
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_en
    localparam logic [7:0] EN_OFF = OFF_EN0 + 8'(2 * c);
    always_ff @(posedge clk) begin
      if (!rst_n)                              en_q[c] <= 8'h00;
      else if (cfg_wr && cfg_addr == EN_OFF)   en_q[c] <= cfg_wdata & EN_WMASK;
    end
    assign chan_en[c] = en_q[c][7];
    assign native[c]  = pif_q[2 * c];
  end

  assign io_en    = cmd_q[0];
  assign irq_code = irq_q;

  always_comb begin
    cfg_rdata = 8'h00;
    case (cfg_addr)
      OFF_CMD: cfg_rdata = cmd_q;
      OFF_PIF: cfg_rdata = pif_q;
      OFF_IRQ: cfg_rdata = {5'b0, irq_q};
      default: ;
    endcase
    for (int i = 0; i < BAR_N; i++) begin
      if (cfg_addr == OFF_BAR0 + 8'(4 * i))        cfg_rdata = bar_lo[i];
      if (cfg_addr == OFF_BAR0 + 8'(4 * i) + 8'd1) cfg_rdata = bar_hi[i];
    end
    for (int c = 0; c < CH_N; c++) begin
      if (cfg_addr == OFF_EN0 + 8'(2 * c)) cfg_rdata = en_q[c];
    end
  end
endmodule

// File: rtl/ide_chan_base.sv
module ide_chan_base
  import ide_dec_pkg::*;
#(
  parameter logic [IO_AW-1:0] FIXED_CMD = 16'h01F0,
  parameter logic [IO_AW-1:0] FIXED_CTL = 16'h03F6
) (
  input  logic             native,
  input  logic [7:0]       cmd_lo,
  input  logic [7:0]       cmd_hi,
  input  logic [7:0]       ctl_lo,
  input  logic [7:0]       ctl_hi,
  output logic [IO_AW-1:0] cmd_base,
  output logic [IO_AW-1:0] ctl_addr
);
  logic [IO_AW-1:0] reloc_cmd;
  logic [IO_AW-1:0] reloc_ctl;

  assign reloc_cmd = {cmd_hi, cmd_lo & CMD_LO_MASK};
  assign reloc_ctl = {ctl_hi, ctl_lo & CTL_LO_MASK} + 16'd2;

  assign cmd_base = native ? reloc_cmd : FIXED_CMD;
  assign ctl_addr = native ? reloc_ctl : FIXED_CTL;
endmodule

// File: rtl/ide_addr_match.sv
module ide_addr_match #(
  parameter int AW        = 16,
  parameter int SPAN_LOG2 = 3
) (
  input  logic          en,
  input  logic [AW-1:0] io_addr,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] ctl_addr,
  output logic          cmd_hit,
  output logic          ctl_hit
);
  assign cmd_hit = en && (io_addr[AW-1:SPAN_LOG2] == cmd_base[AW-1:SPAN_LOG2]);
  assign ctl_hit = en && (io_addr == ctl_addr);
endmodule

// File: rtl/ide_decode_top.sv
module ide_decode_top
  import ide_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [IO_AW-1:0] io_addr,
  output logic [CH_N-1:0]  cmd_hit,
  output logic [CH_N-1:0]  ctl_hit,
  output logic [3:0]       irq_line,
  output logic [CH_N-1:0]  irq_native
);
  logic                  io_en;
  logic [CH_N-1:0]       native;
  logic [CH_N-1:0]       chan_en;
  logic [BAR_N-1:0][7:0] bar_lo;
  logic [BAR_N-1:0][7:0] bar_hi;
  logic [2:0]            irq_code;

  ide_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .io_en    (io_en),
    .native   (native),
    .chan_en  (chan_en),
    .bar_lo   (bar_lo),
    .bar_hi   (bar_hi),
    .irq_code (irq_code)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    logic [IO_AW-1:0] cmd_base;
    logic [IO_AW-1:0] ctl_addr;

    ide_chan_base #(
      .FIXED_CMD(LEG_CMD[c]),
      .FIXED_CTL(LEG_CTL[c])
    ) u_base (
      .native  (native[c]),
      .cmd_lo  (bar_lo[2*c]),
      .cmd_hi  (bar_hi[2*c]),
      .ctl_lo  (bar_lo[2*c+1]),
      .ctl_hi  (bar_hi[2*c+1]),
      .cmd_base(cmd_base),
      .ctl_addr(ctl_addr)
    );

    ide_addr_match #(
      .AW       (IO_AW),
      .SPAN_LOG2(CMD_SPAN_LOG2)
    ) u_match (
      .en      (io_en & chan_en[c]),
      .io_addr (io_addr),
      .cmd_base(cmd_base),
      .ctl_addr(ctl_addr),
      .cmd_hit (cmd_hit[c]),
      .ctl_hit (ctl_hit[c])
    );
  end

  assign irq_line   = irq_code_to_line(irq_code);
  assign irq_native = native;
endmodule

// File: rtl/ide_decode_chk.sv
module ide_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] io_addr,
  input logic [1:0]  cmd_hit,
  input logic [1:0]  ctl_hit,
  input logic [3:0]  irq_line,
  input logic [1:0]  irq_native
);
  // R1: first cycle out of reset decodes nothing
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cmd_hit == 2'b00 && ctl_hit == 2'b00));

  // R2: non-mode bits of the interface byte never move
  assert_pif_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h09) |-> ((cfg_rdata & 8'hFA) == 8'h8A));

  // R3: command BAR low bytes keep the I/O flag and cleared bits 2:1
  assert_cmd_bar_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h10 || cfg_addr == 8'h18) |-> (cfg_rdata[2:0] == 3'b001));

  // R3: control BAR low bytes keep the I/O flag and cleared bit 1
  assert_ctl_bar_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h14 || cfg_addr == 8'h1C) |-> (cfg_rdata[1:0] == 2'b01));

  // R7: clearing the I/O enable silences every channel
  assert_io_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 8'h04 && !cfg_wdata[0]) |=> (cmd_hit == 2'b00 && ctl_hit == 2'b00));

  // R9: the line number always comes from the allowed set
  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line inside {4'd3, 4'd5, 4'd7, 4'd8, 4'd11, 4'd12, 4'd14, 4'd15});

  // R10: interrupt mode changes only through an interface-byte write
  assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == 8'h09) |=> $stable(irq_native));
endmodule

bind ide_decode_top ide_decode_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .io_addr   (io_addr),
  .cmd_hit   (cmd_hit),
  .ctl_hit   (ctl_hit),
  .irq_line  (irq_line),
  .irq_native(irq_native)
);

// File: tb/ide_decode_top_tb_top.sv
`timescale 1ns/1ps
module ide_decode_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = 16'h0000;
  logic [1:0]  cmd_hit, ctl_hit, irq_native;
  logic [3:0]  irq_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ide_decode_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .cmd_hit(cmd_hit), .ctl_hit(ctl_hit), .irq_line(irq_line),
    .irq_native(irq_native)
  );

  // {interface byte, io address, expected cmd_hit, expected ctl_hit}
  localparam int NV = 26;
  localparam logic [27:0] VEC [NV] = '{
    {8'h00, 16'h01F0, 2'b01, 2'b00}, {8'h00, 16'h01F7, 2'b01, 2'b00},
    {8'h00, 16'h01F8, 2'b00, 2'b00}, {8'h00, 16'h01EF, 2'b00, 2'b00},
    {8'h00, 16'h03F6, 2'b00, 2'b01}, {8'h00, 16'h03F7, 2'b00, 2'b00},
    {8'h00, 16'h0170, 2'b10, 2'b00}, {8'h00, 16'h0177, 2'b10, 2'b00},
    {8'h00, 16'h0376, 2'b00, 2'b10},
    {8'h05, 16'h20F8, 2'b01, 2'b00}, {8'h05, 16'h20FF, 2'b01, 2'b00},
    {8'h05, 16'h2100, 2'b00, 2'b00}, {8'h05, 16'h30FE, 2'b00, 2'b01},
    {8'h05, 16'h30FC, 2'b00, 2'b00}, {8'h05, 16'h01F0, 2'b00, 2'b00},
    {8'h05, 16'h1040, 2'b10, 2'b00}, {8'h05, 16'h1047, 2'b10, 2'b00},
    {8'h05, 16'h100A, 2'b00, 2'b10}, {8'h05, 16'h0376, 2'b00, 2'b00},
    {8'h01, 16'h20F8, 2'b01, 2'b00}, {8'h01, 16'h0170, 2'b10, 2'b00},
    {8'h01, 16'h01F0, 2'b00, 2'b00}, {8'h01, 16'h0376, 2'b00, 2'b10},
    {8'h04, 16'h01F0, 2'b01, 2'b00}, {8'h04, 16'h1040, 2'b10, 2'b00},
    {8'h04, 16'h03F6, 2'b00, 2'b01}
  };

  function automatic logic [3:0] exp_line(input int k);
    case (k)
      0: return 4'd3;  1: return 4'd5;  2: return 4'd7;  3: return 4'd8;
      4: return 4'd11; 5: return 4'd12; 6: return 4'd14; default: return 4'd15;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic hits(input string tag, input logic [15:0] a,
                      input logic [1:0] ec, input logic [1:0] el);
    io_addr = a;
    #1;
    chk({tag, " cmd"}, {30'h0, cmd_hit}, {30'h0, ec});
    chk({tag, " ctl"}, {30'h0, ctl_hit}, {30'h0, el});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd("R1 pif", 8'h09, 8'h8A);
    rd("R1 bar0", 8'h10, 8'h01);
    rd("R1 bar1", 8'h14, 8'h01);
    rd("R1 bar2", 8'h18, 8'h01);
    rd("R1 bar3", 8'h1C, 8'h01);
    rd("R1 bar0 hi", 8'h11, 8'h00);
    rd("R1 cmd", 8'h04, 8'h00);
    hits("R1 quiet", 16'h01F0, 2'b00, 2'b00);

    // R2: only mode bits writable
    wr(8'h09, 8'hFF); rd("R2 set", 8'h09, 8'h8F);
    wr(8'h09, 8'h00); rd("R2 clr", 8'h09, 8'h8A);

    // R3: base register masking
    wr(8'h10, 8'hFF); rd("R3 cmd lo", 8'h10, 8'hF9);
    wr(8'h11, 8'h20); rd("R3 cmd hi", 8'h11, 8'h20);
    wr(8'h14, 8'hFF); rd("R3 ctl lo", 8'h14, 8'hFD);
    wr(8'h15, 8'h30);
    wr(8'h18, 8'h40); rd("R3 sec cmd lo", 8'h18, 8'h41);
    wr(8'h19, 8'h10);
    wr(8'h1C, 8'h08); rd("R3 sec ctl lo", 8'h1C, 8'h09);
    wr(8'h1D, 8'h10); rd("R3 sec ctl hi", 8'h1D, 8'h10);

    // R7: enable register masks
    wr(8'h04, 8'hFF); rd("R7 cmd mask", 8'h04, 8'h05);
    wr(8'h41, 8'hFF); rd("R7 en mask", 8'h41, 8'hF3);
    wr(8'h41, 8'h80);
    wr(8'h43, 8'h80);

    // R4 R5 R6 R8 R10: vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] p;
      p = VEC[i][27:20];
      wr(8'h09, p);
      hits($sformatf("R4/R5/R6/R8 vec%0d", i), VEC[i][19:4], VEC[i][3:2], VEC[i][1:0]);
      chk($sformatf("R10 vec%0d", i), {30'h0, irq_native}, {30'h0, p[2], p[0]});
    end

    // R7: per-channel enable gating
    wr(8'h09, 8'h00);
    wr(8'h41, 8'h00);
    hits("R7 pri off", 16'h01F0, 2'b00, 2'b00);
    hits("R7 sec stays", 16'h0170, 2'b10, 2'b00);
    wr(8'h41, 8'h80);
    hits("R7 pri back", 16'h03F6, 2'b00, 2'b01);

    // R11: old config holds until the capturing edge
    io_addr = 16'h0170;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h04; cfg_wdata = 8'h00;
    #1;
    chk("R11 before edge", {30'h0, cmd_hit}, 32'h2);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R11 after edge", {30'h0, cmd_hit}, 32'h0);
    hits("R7 io off", 16'h03F6, 2'b00, 2'b00);
    wr(8'h04, 8'h01);
    hits("R11 restored", 16'h0170, 2'b10, 2'b00);

    // R9: interrupt code map
    for (int k = 0; k < 8; k++) begin
      wr(8'h44, 8'(k));
      #1;
      chk($sformatf("R9 code%0d", k), {28'h0, irq_line}, {28'h0, exp_line(k)});
    end
    wr(8'h44, 8'hFA);
    rd("R9 upper bits", 8'h44, 8'h02);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule